// File: doc/BRIEF.md
# Randomized-Order Shared Substitution Sequencer

This block computes one layer of eight 6-in/4-out substitution boxes by sending the groups, one per evaluation cycle, through a single shared lookup. The order of evaluation changes from one operation to the next. A 4-bit random selector chooses the first box. After each evaluation, the selector is updated from the data just consumed. When the updated selector points at a box that has already been done, a one-index-per-cycle probe walks to the nearest free box. The direction of that walk is set by the parity of the selector. The mask is never combined with the data. It only decides when each box is evaluated, so the power profile moves around in time while the result stays the same.

To use the block, a host pulses `start` and supplies the 48-bit input word and the 4-bit seed in the same cycle. It then waits for `done`. At that point `dout` holds the finished 32-bit layer, packed in native box order whatever the visit order was. The evaluation trace (`eval_valid`, `eval_idx`) shows which box is being evaluated in each cycle.

The controller has four states:
- `ST_IDLE` waits for a start.
- `ST_EVAL` looks up one box per cycle.
- `ST_PROBE` steps over boxes that are already done.
- `ST_FINISH` raises `done` for one cycle.

The transitions are:
- IDLE→EVAL on start.
- EVAL→EVAL when the updated selector points at a free box.
- EVAL→PROBE when it points at a done box.
- PROBE→PROBE while the candidate box is done.
- PROBE→EVAL when the candidate box is free.
- EVAL→FINISH after the eighth evaluation.
- FINISH→IDLE unconditionally.

Top module: `rsb_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `done`, `busy` and `eval_valid` are 0 and `dout` is zero.
- R2: Box k takes input group `din[47-6k -: 6]`, where k=0 is the most significant group. Let r = {g[5],g[0]} and x = g[4:1]. The box output is (M·(x⊕C)+A) mod 16, where C=(3k+5r) mod 16, M=2·((k+r) mod 8)+1 and A=(7k+2r+1) mod 16. This output is placed at `dout[31-4k -: 4]`, whatever the evaluation order.
- R3: The first box evaluated after a start is box `seed[2:0]`. It is evaluated in the cycle after the start is accepted.
- R4: After box b is evaluated, the selector becomes its previous value XOR b's middle bits g[4:1]. If box (selector mod 8) has not been evaluated, that box is evaluated in the very next cycle.
- R5: If box (selector mod 8) has already been evaluated, a probe step is taken. When the 4-bit selector has odd parity, the step goes to index+1 mod 8; when the parity is even, it goes to index−1 mod 8. Each probe cycle examines one candidate. The probe keeps the same direction until it finds a free box, and that box is evaluated in the following cycle. The selector does not change during probing.
- R6: Every start results in exactly eight evaluation cycles, and each box index 0..7 is evaluated exactly once.
- R7: `done` is high for exactly one cycle. It comes on the cycle after the eighth evaluation, so the start-to-done distance equals 8 + (number of probe cycles) + 1 cycles.
- R8: A `start` that arrives while `busy` is high is ignored. The running operation keeps its order, its data and its result.
- R9: `busy` is high from the cycle after an accepted start through the `done` cycle, and low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| din | input | 48 | Eight 6-bit substitution inputs, box 0 in bits 47:42 |
| seed | input | 4 | Random selector; low three bits pick the first box |
| dout | output | 32 | Completed substitution layer, box 0 in bits 31:28 |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| eval_valid | output | 1 | A box is being evaluated this cycle |
| eval_idx | output | 3 | Index of the box under evaluation or probe |

## Verification
The bench goes after the following corner cases:
- Inputs whose middle bits are all zero. These freeze the selector, so every later step collides and the probe has to cross long runs of done boxes. A design that steps the wrong way here, or lets the selector drift while it probes, produces a visit order that differs from the bench's own model of the rule.
- Seeds of both parities, and wrap-around at index 0 and index 7. A design that wraps by 7 in the wrong place would evaluate a box twice or never reach one. That shows up as a duplicated or missing index and a wrong `dout` nibble.
- A second start in the middle of an operation. A design that accepts it would restart with the new seed and data and show a different trace.
- A reset during an operation. A design that fails to clear would keep `busy` asserted or leave stale result bits.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_PROBE  = 2'd2,
        ST_FINISH = 2'd3
    } rsb_state_e;

endpackage

// File: rtl/rsb_lookup.sv
// Shared computed substitution: one 6-bit group of box box_idx -> 4-bit result.
module rsb_lookup #(
    parameter int IDXW = 3,
    parameter int OW   = 4
) (
    input  logic [IDXW-1:0] box_idx,
    input  logic [OW+1:0]   grp,
    output logic [OW-1:0]   sub
);
    localparam int GW = OW + 2;

    logic [1:0]    row;
    logic [OW-1:0] mid;
    logic [15:0]   k16, r16, cst, mul, add, prod;

    always_comb begin
        row  = {grp[GW-1], grp[0]};
        mid  = grp[GW-2:1];
        k16  = 16'(box_idx);
        r16  = 16'(row);
        cst  = 16'(3 * k16 + 5 * r16);
        mul  = 16'(2 * ((k16 + r16) & 16'd7) + 1);
        add  = 16'(7 * k16 + 2 * r16 + 1);
        prod = 16'(mul * 16'(mid ^ cst[OW-1:0]));
        sub  = prod[OW-1:0] + add[OW-1:0];
    end

endmodule

// File: rtl/rsb_pick.sv
// Next-index decision after an evaluation: selector update, free test, probe start.
module rsb_pick #(
    parameter int IDXW = 3,
    parameter int OW   = 4
) (
    input  logic [(1<<IDXW)-1:0] vis_nxt,
    input  logic [OW-1:0]        sel_cur,
    input  logic [OW-1:0]        mid,
    output logic [OW-1:0]        sel_new,
    output logic [IDXW-1:0]      cand,
    output logic                 cand_free,
    output logic                 all_done,
    output logic                 step_up,
    output logic [IDXW-1:0]      probe_start
);
    always_comb begin
        sel_new     = sel_cur ^ mid;
        cand        = sel_new[IDXW-1:0];
        cand_free   = !vis_nxt[cand];
        all_done    = &vis_nxt;
        step_up     = ^sel_new;
        probe_start = step_up ? cand + 1'b1 : cand - 1'b1;
    end

endmodule

// File: rtl/rsb_sequencer.sv
module rsb_sequencer
    import rsb_pkg::*;
#(
    parameter int IDXW = 3,
    parameter int OW   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [(1<<IDXW)*(OW+2)-1:0]   din,
    input  logic [OW-1:0]                 seed,
    output logic [(1<<IDXW)*OW-1:0]       dout,
    output logic                          done,
    output logic                          busy,
    output logic                          eval_valid,
    output logic [IDXW-1:0]               eval_idx
);
    localparam int NBOX = 1 << IDXW;
    localparam int GW   = OW + 2;
    localparam int DW   = NBOX * GW;
    localparam int RW   = NBOX * OW;

    rsb_state_e       state_q, state_d;
    logic [IDXW-1:0]  idx_q;
    logic [OW-1:0]    sel_q;
    logic [NBOX-1:0]  vis_q;
    logic [NBOX-1:0]  vis_nxt;
    logic [RW-1:0]    res_q;
    logic [DW-1:0]    din_q;
    logic             dir_q;

    logic [GW-1:0]    grp;
    logic [OW-1:0]    sub;
    logic [OW-1:0]    sel_new;
    logic [IDXW-1:0]  cand, probe_start;
    logic             cand_free, all_done, step_up;

    always_comb begin
        grp     = din_q[(NBOX-1-int'(idx_q))*GW +: GW];
        vis_nxt = vis_q | (NBOX'(1) << idx_q);
    end

    rsb_lookup #(.IDXW(IDXW), .OW(OW)) u_lookup (
        .box_idx (idx_q),
        .grp     (grp),
        .sub     (sub)
    );

    rsb_pick #(.IDXW(IDXW), .OW(OW)) u_pick (
        .vis_nxt     (vis_nxt),
        .sel_cur     (sel_q),
        .mid         (grp[GW-2:1]),
        .sel_new     (sel_new),
        .cand        (cand),
        .cand_free   (cand_free),
        .all_done    (all_done),
        .step_up     (step_up),
        .probe_start (probe_start)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_EVAL;
            ST_EVAL:   begin
                if (all_done)       state_d = ST_FINISH;
                else if (cand_free) state_d = ST_EVAL;
                else                state_d = ST_PROBE;
            end
            ST_PROBE:  if (!vis_q[idx_q]) state_d = ST_EVAL;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            sel_q <= '0;
            vis_q <= '0;
            res_q <= '0;
            din_q <= '0;
            dir_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q <= seed[IDXW-1:0];
                        sel_q <= seed;
                        vis_q <= '0;
                        res_q <= '0;
                        din_q <= din;
                    end
                end
                ST_EVAL: begin
                    res_q[(NBOX-1-int'(idx_q))*OW +: OW] <= sub;
                    vis_q <= vis_nxt;
                    sel_q <= sel_new;
                    if (!all_done) begin
                        if (cand_free) begin
                            idx_q <= cand;
                        end else begin
                            idx_q <= probe_start;
                            dir_q <= step_up;
                        end
                    end
                end
                ST_PROBE: begin
                    if (vis_q[idx_q]) idx_q <= dir_q ? idx_q + 1'b1 : idx_q - 1'b1;
                end
                ST_FINISH: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done       = (state_q == ST_FINISH);
        busy       = (state_q != ST_IDLE);
        eval_valid = (state_q == ST_EVAL);
        eval_idx   = idx_q;
        dout       = res_q;
    end

    // Run length of consecutive probe cycles, for the bounded-probe check
    logic [IDXW:0] probe_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  probe_run <= '0;
        else if (state_q == ST_PROBE) probe_run <= probe_run + 1'b1;
        else                         probe_run <= '0;
    end

    a_r3_first_box: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (eval_valid && eval_idx == $past(seed[IDXW-1:0])));

    a_r6_no_revisit: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid |-> !vis_q[eval_idx]);

    a_r5_probe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE) |-> (probe_run < (IDXW+1)'(NBOX-1)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_full: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&vis_q));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ((vis_q & $past(vis_q)) == $past(vis_q)));

endmodule

// File: tb/tb_rsb_sequencer.sv
`timescale 1ns/1ps
module tb_rsb_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] din = '0;
    logic [3:0]  seed = '0;
    logic [31:0] dout;
    logic        done, busy, eval_valid;
    logic [2:0]  eval_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rsb_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din), .seed(seed),
        .dout(dout), .done(done), .busy(busy),
        .eval_valid(eval_valid), .eval_idx(eval_idx)
    );

    typedef struct packed { logic [3:0] s; logic [47:0] d; } stim_t;
    localparam stim_t STIM [10] = '{
        '{4'h0, 48'h0000_0000_0000},
        '{4'h7, 48'h0000_0000_0000},
        '{4'h1, 48'hFFFF_FFFF_FFFF},
        '{4'hE, 48'hFFFF_FFFF_FFFF},
        '{4'h3, 48'h1234_5678_9ABC},
        '{4'hC, 48'hA5A5_A5A5_A5A5},
        '{4'h8, 48'h8618_6186_1861},
        '{4'h5, 48'h0410_4104_1041},
        '{4'hB, 48'hFEDC_BA98_7654},
        '{4'h6, 48'h7E1E_81F0_3C99}
    };

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] lut(int k, logic [5:0] g);
        int r, x, c, m, a;
        r = {g[5], g[0]};
        x = int'(g[4:1]);
        c = (3*k + 5*r) % 16;
        m = 2*((k + r) % 8) + 1;
        a = (7*k + 2*r + 1) % 16;
        return 4'((m * (x ^ c) + a) % 16);
    endfunction

    function automatic logic [31:0] ref_layer(logic [47:0] d);
        logic [31:0] o;
        for (int k = 0; k < 8; k++) o[31-4*k -: 4] = lut(k, d[47-6*k -: 6]);
        return o;
    endfunction

    // Behavioural model of the selector rule (R3, R4, R5)
    task automatic model(input logic [3:0] s, input logic [47:0] d,
                         output logic [2:0] ord [8], output int probes);
        logic [7:0] vis = '0;
        logic [3:0] sel = s;
        logic [2:0] idx = s[2:0];
        logic [2:0] c;
        bit up;
        probes = 0;
        for (int n = 0; n < 8; n++) begin
            ord[n] = idx;
            vis[idx] = 1'b1;
            sel = sel ^ d[47-6*int'(idx)-1 -: 4];
            if (n == 7) break;
            c = sel[2:0];
            if (vis[c]) begin
                up = ^sel;
                do begin
                    c = up ? c + 3'd1 : c - 3'd1;
                    probes++;
                end while (vis[c]);
            end
            idx = c;
        end
    endtask

    task automatic run_case(logic [3:0] s, logic [47:0] d, bit ign, string tag);
        logic [2:0] exp_ord [8];
        logic [2:0] got [8];
        int probes, nev, cnt;
        logic [7:0] seen;
        bit ord_ok;
        model(s, d, exp_ord, probes);
        nev = 0;
        @(negedge clk);
        start = 1'b1; seed = s; din = d;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        chk(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
        chk(eval_valid && eval_idx == s[2:0], "R3", {tag, " first box"}, eval_idx, s[2:0]);
        while (!done && cnt < 200) begin
            if (eval_valid) begin
                if (nev < 8) got[nev] = eval_idx;
                nev++;
            end
            if (ign && cnt == 3) begin start = 1'b1; seed = ~s; din = ~d; end
            if (ign && cnt == 4) start = 1'b0;
            @(negedge clk);
            cnt++;
        end
        chk(done == 1'b1, "R7", {tag, " done seen"}, done, 1);
        chk(cnt == 8 + probes + 1, "R7", {tag, " start-to-done cycles"}, cnt, 8 + probes + 1);
        chk(nev == 8, "R6", {tag, " evaluation count"}, nev, 8);
        seen = '0;
        ord_ok = 1'b1;
        for (int n = 0; n < 8 && n < nev; n++) begin
            seen[got[n]] = 1'b1;
            if (got[n] != exp_ord[n]) ord_ok = 1'b0;
        end
        chk(seen == 8'hFF, "R6", {tag, " each box once"}, seen, 8'hFF);
        chk(ord_ok, ign ? "R8" : "R5", {tag, " visit order vs model (R4 R5)"},
            {got[0],got[1],got[2],got[3],got[4],got[5],got[6],got[7]},
            {exp_ord[0],exp_ord[1],exp_ord[2],exp_ord[3],exp_ord[4],exp_ord[5],exp_ord[6],exp_ord[7]});
        chk(dout == ref_layer(d), ign ? "R8" : "R2", {tag, " result word"}, dout, ref_layer(d));
        @(negedge clk);
        chk(done == 1'b0, "R7", {tag, " done single cycle"}, done, 0);
        chk(busy == 1'b0, "R9", {tag, " busy released"}, busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog timeout actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done && !busy && !eval_valid, "R1", "outputs in reset", {done,busy,eval_valid}, 0);
        chk(dout == 32'h0, "R1", "dout in reset", dout, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !eval_valid && dout == 0, "R1", "after release", dout, 0);

        foreach (STIM[i]) run_case(STIM[i].s, STIM[i].d, 1'b0, "table");

        for (int i = 0; i < 300; i++)
            run_case(4'($urandom), {16'($urandom), 32'($urandom)}, 1'b0, "random");

        // R8: start while busy
        run_case(4'h2, 48'h0000_0000_0000, 1'b1, "busy-start");
        run_case(4'h9, 48'h3C3C_0F0F_C3C3, 1'b1, "busy-start");

        // R1: reset in mid-operation
        @(negedge clk);
        start = 1'b1; seed = 4'h4; din = 48'hDEAD_BEEF_CAFE;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !eval_valid && dout == 0, "R1", "reset mid-run", {busy, dout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(4'hF, 48'h0123_4567_89AB, 1'b0, "post-reset");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule